// File: doc/BRIEF.md
# Packed-Decimal Add/Subtract Unit with Selectable Flag Semantics

This unit is the arithmetic core for an 8-bit accumulator machine. It performs add-with-carry and subtract-with-borrow on an accumulator byte and an operand byte. A decimal-mode input selects packed-BCD arithmetic, in which each byte holds two decimal digits. A variant input picks one of two flag conventions for decimal operations. The older convention takes the N, V and Z flags from the unadjusted intermediate sum. The newer convention takes all three from the adjusted result and needs one extra clock to do so.

One operation passes through per transaction. The operation is accepted on a valid/ready input handshake and all operand fields are captured at that moment. The unit then produces one result with four flags, held under a valid/ready output handshake. The unit raises an extra-cycle request during the stall that a newer-variant decimal operation adds, so that the instruction sequencer can stretch its own timing. Every operand byte has a defined result, including bytes whose nibbles are above 9.

Top module: `bcd_alu_unit`

## Requirements
- R1: Binary add (decimalMode=0, opSub=0): result = (accum + operand + carryIn) mod 256 and flagC = bit 8 of that sum. flagV is set when accum and operand share bit 7 and result bit 7 differs from them. flagN = result bit 7. flagZ = (result == 0).
- R2: Binary subtract (decimalMode=0, opSub=1) is R1 applied to accum and the ones-complement of operand. flagC is therefore an inverted borrow: carryIn=1 means no borrow, and flagC=1 means no borrow occurred.
- R3: Decimal add: lo = accumLo + operandLo + carryIn. If lo > 9, lo becomes ((lo+6) AND 0x0F) + 0x10. Then seq = accumHigh nibble·16 + operandHigh nibble·16 + lo. If seq ≥ 0xA0, seq is raised by 0x60. result = seq mod 256 and flagC = (seq > 0xFF). This gives 0x09+0x01 = 0x10 and 0x99+0x01 = 0x00 with carry.
- R4: Decimal subtract: result digits follow packed-BCD borrow rules, so 0x10−0x01 (carryIn=1) = 0x09 and 0x00−0x01 = 0x99. In both variants flagC equals the binary-subtract carry of R2.
- R5: Older variant (cmosMode=0) in decimal mode. For add, flagN and flagV come from the pre-adjust seq of R3, using the R1 sign rule against operand. flagZ comes from the binary sum of R1. For subtract, N, V and Z all equal the binary-subtract flags of R2. The result is computed as in R3 and R4, with the low digit adjusted before the high part is formed and 0x60 taken off when the total is negative.
- R6: Newer variant (cmosMode=1) in decimal mode: flagN = result bit 7 and flagZ = (result == 0). flagV uses the R1 rule (for add) or the R2 rule (for subtract), computed against the final result. The subtract result is accum − operand + carryIn − 1, less 0x60 if that is negative, and less another 6 if the raw low-digit difference was negative.
- R7: Operands with a nibble above 9 follow the same formulas as R3–R6 with no special case, so every input byte has one defined output.
- R8: A newer-variant decimal operation holds extraCycle high for exactly one cycle, starting one cycle after acceptance, and outValid rises one cycle later than for any other operation. No other operation ever raises extraCycle.
- R9: inReady is high only while no operation is in flight. Once outValid is high, outValid and all result and flag outputs stay unchanged until outReady is high.
- R10: After reset, inReady=1, outValid=0 and extraCycle=0.
- R11: Input fields that change while an operation is in flight do not affect that operation's result, and no second operation is accepted before the first is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Unit idle and able to accept |
| accum | input | 8 | Accumulator operand |
| operand | input | 8 | Second operand |
| carryIn | input | 1 | Carry in (inverted borrow for subtract) |
| decimalMode | input | 1 | 1 selects packed-BCD arithmetic |
| opSub | input | 1 | 0 add-with-carry, 1 subtract-with-borrow |
| cmosMode | input | 1 | 0 older flag semantics, 1 newer semantics |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| result | output | 8 | Result byte |
| flagN | output | 1 | Negative flag |
| flagV | output | 1 | Overflow flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| extraCycle | output | 1 | Extra-cycle request during the decimal stall |

## Verification
Assertions check every cycle that extraCycle follows exactly the newer-variant decimal acceptances and lasts one cycle, that ready and valid never overlap, and that a held result stays stable. They also check that a binary add satisfies its carry identity and that decimal operations on valid BCD digits never produce a digit above 9. The split of N, V and Z between intermediate and final values, the subtract adjustment in each variant and the behaviour on invalid nibbles can only be shown by the bench scenarios. These compare each result against a reference model over directed corner values and strided sweeps of both operand bytes and the carry.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NIB_W   = DATA_W / 2;
  localparam int unsigned CALC_W  = DATA_W + 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STALL = 2'd1,
    ST_EVAL  = 2'd2,
    ST_DONE  = 2'd3
  } aluState_t;

  typedef struct packed {
    logic capture;
    logic loadRes;
  } ctrlStrobe_t;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } aluFlags_t;
endpackage

// File: rtl/bcd_alu_ctrl.sv
module bcd_alu_ctrl
  import bcd_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        needExtra,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic        extraCycle,
  output ctrlStrobe_t strobe
);
  aluState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (inValid) stateNext = needExtra ? ST_STALL : ST_EVAL;
      ST_STALL: stateNext = ST_EVAL;
      ST_EVAL:  stateNext = ST_DONE;
      ST_DONE:  if (outReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inReady        = (state == ST_IDLE);
  assign outValid       = (state == ST_DONE);
  assign extraCycle     = (state == ST_STALL);
  assign strobe.capture = inValid && (state == ST_IDLE);
  assign strobe.loadRes = (state == ST_EVAL);

  assert_extra_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    extraCycle |=> !extraCycle);
  assert_extra_follows_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && needExtra) |=> extraCycle);
  assert_no_extra_plain_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !needExtra) |=> !extraCycle);
  assert_ready_valid_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));
endmodule

// File: rtl/bcd_alu_dp.sv
module bcd_alu_dp
  import bcd_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] accumIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic              carryIn,
  input  logic              decimalIn,
  input  logic              subIn,
  input  logic              cmosIn,
  output logic [DATA_W-1:0] result,
  output aluFlags_t         flags
);
  typedef logic signed [CALC_W-1:0] calc_t;

  logic [DATA_W-1:0] aReg, bReg;
  logic              cReg, dReg, sReg, mReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg <= '0; bReg <= '0;
      cReg <= 1'b0; dReg <= 1'b0; sReg <= 1'b0; mReg <= 1'b0;
    end else if (strobe.capture) begin
      aReg <= accumIn; bReg <= operandIn;
      cReg <= carryIn; dReg <= decimalIn; sReg <= subIn; mReg <= cmosIn;
    end
  end

  // shared binary adder: operand complemented for subtract
  logic [DATA_W-1:0] bEff, binRes;
  logic [DATA_W:0]   binSum;
  logic              binV;

  always_comb begin
    bEff   = sReg ? ~bReg : bReg;
    binSum = {1'b0, aReg} + {1'b0, bEff} + {{DATA_W{1'b0}}, cReg};
    binRes = binSum[DATA_W-1:0];
    binV   = ~(aReg[DATA_W-1] ^ bEff[DATA_W-1]) & (aReg[DATA_W-1] ^ binRes[DATA_W-1]);
  end

  // decimal paths, computed in signed arithmetic
  calc_t aLo, bLo, aHi, bHi, aFull, bFull, cIn;
  calc_t addLo, addSeq, addAdj, subLoRaw, subLoAdj, subOld, subNew;
  logic  addC;

  always_comb begin
    aLo   = calc_t'({{(CALC_W-NIB_W){1'b0}}, aReg[NIB_W-1:0]});
    bLo   = calc_t'({{(CALC_W-NIB_W){1'b0}}, bReg[NIB_W-1:0]});
    aHi   = calc_t'({{(CALC_W-DATA_W){1'b0}}, aReg[DATA_W-1:NIB_W], {NIB_W{1'b0}}});
    bHi   = calc_t'({{(CALC_W-DATA_W){1'b0}}, bReg[DATA_W-1:NIB_W], {NIB_W{1'b0}}});
    aFull = calc_t'({{(CALC_W-DATA_W){1'b0}}, aReg});
    bFull = calc_t'({{(CALC_W-DATA_W){1'b0}}, bReg});
    cIn   = calc_t'({{(CALC_W-1){1'b0}}, cReg});

    addLo = aLo + bLo + cIn;
    if (addLo > 12'sd9) addLo = ((addLo + 12'sd6) & 12'sd15) + 12'sd16;
    addSeq = aHi + bHi + addLo;
    addAdj = (addSeq >= 12'sd160) ? addSeq + 12'sd96 : addSeq;
    addC   = (addAdj > 12'sd255);

    subLoRaw = aLo - bLo + cIn - 12'sd1;
    subLoAdj = (subLoRaw < 12'sd0) ? ((subLoRaw - 12'sd6) & 12'sd15) - 12'sd16 : subLoRaw;
    subOld   = aHi - bHi + subLoAdj;
    if (subOld < 12'sd0) subOld = subOld - 12'sd96;

    subNew = aFull - bFull + cIn - 12'sd1;
    if (subNew < 12'sd0)   subNew = subNew - 12'sd96;
    if (subLoRaw < 12'sd0) subNew = subNew - 12'sd6;
  end

  // result and flag selection by mode and variant
  logic [DATA_W-1:0] resNext;
  aluFlags_t         flagsNext;

  always_comb begin
    resNext   = binRes;
    flagsNext = '{n: binRes[DATA_W-1], v: binV, z: (binRes == '0), c: binSum[DATA_W]};
    if (dReg && !sReg) begin
      resNext     = addAdj[DATA_W-1:0];
      flagsNext.c = addC;
      if (mReg) begin
        flagsNext.n = resNext[DATA_W-1];
        flagsNext.z = (resNext == '0);
        flagsNext.v = (aReg[DATA_W-1] ^ resNext[DATA_W-1]) & ~(aReg[DATA_W-1] ^ bReg[DATA_W-1]);
      end else begin
        flagsNext.n = addSeq[DATA_W-1];
        flagsNext.v = (aReg[DATA_W-1] ^ addSeq[DATA_W-1]) & ~(aReg[DATA_W-1] ^ bReg[DATA_W-1]);
      end
    end else if (dReg && sReg) begin
      resNext = mReg ? subNew[DATA_W-1:0] : subOld[DATA_W-1:0];
      if (mReg) begin
        flagsNext.n = resNext[DATA_W-1];
        flagsNext.z = (resNext == '0);
        flagsNext.v = (aReg[DATA_W-1] ^ resNext[DATA_W-1]) & (aReg[DATA_W-1] ^ bReg[DATA_W-1]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      flags  <= '0;
    end else if (strobe.loadRes) begin
      result <= resNext;
      flags  <= flagsNext;
    end
  end

  assert_bin_add_identity_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!dReg && !sReg) |-> ({flagsNext.c, resNext} ==
      ({1'b0, aReg} + {1'b0, bReg} + {{DATA_W{1'b0}}, cReg})));
  assert_bcd_digits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dReg && aReg[7:4] <= 4'd9 && aReg[3:0] <= 4'd9 && bReg[7:4] <= 4'd9 && bReg[3:0] <= 4'd9)
      |-> (resNext[7:4] <= 4'd9 && resNext[3:0] <= 4'd9));
endmodule

// File: rtl/bcd_alu_unit.sv
module bcd_alu_unit
  import bcd_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] accum,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              decimalMode,
  input  logic              opSub,
  input  logic              cmosMode,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagV,
  output logic              flagZ,
  output logic              flagC,
  output logic              extraCycle
);
  ctrlStrobe_t strobe;
  aluFlags_t   flags;

  bcd_alu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .needExtra(decimalMode && cmosMode), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .extraCycle(extraCycle),
    .strobe(strobe)
  );

  bcd_alu_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .accumIn(accum), .operandIn(operand), .carryIn(carryIn),
    .decimalIn(decimalMode), .subIn(opSub), .cmosIn(cmosMode),
    .result(result), .flags(flags)
  );

  assign flagN = flags.n;
  assign flagV = flags.v;
  assign flagZ = flags.z;
  assign flagC = flags.c;

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(result) && $stable(flags)));
endmodule

// File: tb/sim_bcd_alu_unit.sv
`timescale 1ns/1ps
module sim_bcd_alu_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, carryIn = 1'b0, decimalMode = 1'b0, opSub = 1'b0, cmosMode = 1'b0;
  logic outReady = 1'b1;
  logic [7:0] accum = '0, operand = '0;
  logic inReady, outValid, flagN, flagV, flagZ, flagC, extraCycle;
  logic [7:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bcd_alu_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .accum(accum), .operand(operand), .carryIn(carryIn),
    .decimalMode(decimalMode), .opSub(opSub), .cmosMode(cmosMode),
    .outValid(outValid), .outReady(outReady), .result(result),
    .flagN(flagN), .flagV(flagV), .flagZ(flagZ), .flagC(flagC),
    .extraCycle(extraCycle)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  // reference: returns {result[7:0], N, V, Z, C}
  function automatic int refModel(int a, int b, int c, bit d, bit s, bit m);
    int bb, bin, br, lo, t, res;
    bit n, v, z, co, binV;
    bb   = s ? ((~b) & 255) : b;
    bin  = a + bb + c;
    br   = bin & 255;
    binV = (((~(a ^ bb)) & (a ^ br)) & 128) != 0;
    res = br; n = br >= 128; z = br == 0; v = binV; co = bin > 255;
    if (d && !s) begin
      lo = (a & 15) + (b & 15) + c;
      if (lo > 9) lo = ((lo + 6) & 15) + 16;
      t = (a & 240) + (b & 240) + lo;
      if (!m) begin
        n = (t & 128) != 0;
        v = (((a ^ t) & ~(a ^ b)) & 128) != 0;
      end
      if (t >= 160) t = t + 96;
      res = t & 255; co = t > 255;
      if (m) begin
        n = res >= 128; z = res == 0;
        v = (((a ^ res) & ~(a ^ b)) & 128) != 0;
      end
    end else if (d && s) begin
      lo = (a & 15) - (b & 15) + c - 1;
      if (m) begin
        t = a - b + c - 1;
        if (t < 0) t = t - 96;
        if (lo < 0) t = t - 6;
        res = t & 255;
        n = res >= 128; z = res == 0;
        v = (((a ^ res) & (a ^ b)) & 128) != 0;
      end else begin
        if (lo < 0) lo = ((lo - 6) & 15) - 16;
        t = (a & 240) - (b & 240) + lo;
        if (t < 0) t = t - 96;
        res = t & 255;
      end
    end
    return (res << 4) | (int'(n) << 3) | (int'(v) << 2) | (int'(z) << 1) | int'(co);
  endfunction

  function automatic int packOut();
    return (int'(result) << 4) | (int'(flagN) << 3) | (int'(flagV) << 2) | (int'(flagZ) << 1) | int'(flagC);
  endfunction

  // one full transaction; checks result, flags and latency
  task automatic doOp(string req, int a, int b, int c, bit d, bit s, bit m);
    int lat;
    bit wantExtra;
    wantExtra = d && m;
    while (!inReady) @(negedge clk);
    accum = 8'(a); operand = 8'(b); carryIn = c[0];
    decimalMode = d; opSub = s; cmosMode = m; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    if (wantExtra || extraCycle) check("R8 extraCycle after accept", int'(extraCycle), int'(wantExtra));
    lat = 1;
    while (!outValid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    if (wantExtra) check("R8 latency", lat, 3);
    else if (lat != 2) check("R8 latency", lat, 2);
    check(req, packOut(), refModel(a, b, c, d, s, m));
    @(negedge clk);
  endtask

  task automatic resetScenario();
    check("R10 inReady after reset", int'(inReady), 1);
    check("R10 outValid after reset", int'(outValid), 0);
    check("R10 extraCycle after reset", int'(extraCycle), 0);
  endtask

  task automatic binaryScenario();
    doOp("R1 binary add 0x7F+0x01", 8'h7F, 8'h01, 0, 0, 0, 0);
    check("R1 overflow 0x7F+0x01", packOut(), (8'h80 << 4) | 4'b1100);
    doOp("R1 binary add 0xFF+0x01", 8'hFF, 8'h01, 0, 0, 0, 1);
    check("R1 wrap to zero", packOut(), 4'b0011);
    doOp("R2 binary sub 0x00-0x01", 8'h00, 8'h01, 1, 0, 1, 0);
    check("R2 borrow", packOut(), (8'hFF << 4) | 4'b1000);
    for (int a = 0; a < 256; a += 9)
      for (int b = 0; b < 256; b += 11) begin
        doOp("R1 binary add sweep", a, b, (a >> 1) & 1, 0, 0, a & 1);
        doOp("R2 binary sub sweep", a, b, (b >> 1) & 1, 0, 1, b & 1);
      end
  endtask

  task automatic decimalDirected();
    doOp("R3 0x09+0x01", 8'h09, 8'h01, 0, 1, 0, 0);
    check("R3 0x09+0x01 result", int'(result), 8'h10);
    doOp("R3 0x99+0x01", 8'h99, 8'h01, 0, 1, 0, 1);
    check("R3 0x99+0x01 result/carry", {int'(result), int'(flagC)}, 1);
    check("R6 0x99+0x01 zero from result", int'(flagZ), 1);
    doOp("R5 0x99+0x01 older", 8'h99, 8'h01, 0, 1, 0, 0);
    check("R5 zero from binary sum", int'(flagZ), 0);
    check("R5 negative from intermediate", int'(flagN), 1);
    doOp("R4 0x10-0x01", 8'h10, 8'h01, 1, 1, 1, 0);
    check("R4 0x10-0x01 result", int'(result), 8'h09);
    doOp("R4 0x00-0x01", 8'h00, 8'h01, 1, 1, 1, 1);
    check("R4 0x00-0x01 result", int'(result), 8'h99);
    check("R4 0x00-0x01 borrow", int'(flagC), 0);
  endtask

  task automatic variantSweep(bit m, string reqAdd, string reqSub);
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 7)
        for (int c = 0; c < 2; c++) begin
          doOp(reqAdd, a, b, c, 1, 0, m);
          doOp(reqSub, a, b, c, 1, 1, m);
        end
  endtask

  task automatic invalidNibbles();
    for (int x = 0; x < 36; x++) begin
      int a, b;
      a = ((10 + x / 6) << 4) | (10 + x % 6);
      b = 8'h9F - x;
      doOp("R7 invalid add older", a, b, x & 1, 1, 0, 0);
      doOp("R7 invalid add newer", a, b, x & 1, 1, 0, 1);
      doOp("R7 invalid sub older", b, a, x & 1, 1, 1, 0);
      doOp("R7 invalid sub newer", b, a, x & 1, 1, 1, 1);
    end
  endtask

  task automatic holdScenario();
    int held;
    outReady = 1'b0;
    while (!inReady) @(negedge clk);
    accum = 8'h45; operand = 8'h38; carryIn = 1'b1;
    decimalMode = 1'b1; opSub = 1'b0; cmosMode = 1'b1; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check("R9 inReady low while busy", int'(inReady), 0);
    while (!outValid) @(negedge clk);
    held = packOut();
    check("R9 held value", held, refModel(8'h45, 8'h38, 1, 1, 0, 1));
    repeat (4) @(negedge clk);
    check("R9 outValid held", int'(outValid), 1);
    check("R9 outputs stable", packOut(), held);
    outReady = 1'b1;
    @(negedge clk);
    check("R9 released", int'(outValid), 0);
    check("R9 ready again", int'(inReady), 1);
  endtask

  task automatic busyScenario();
    while (!inReady) @(negedge clk);
    accum = 8'h27; operand = 8'h15; carryIn = 1'b0;
    decimalMode = 1'b1; opSub = 1'b1; cmosMode = 1'b0; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    accum = 8'hFF; operand = 8'hEE; carryIn = 1'b1; opSub = 1'b0; cmosMode = 1'b1;
    while (!outValid) @(negedge clk);
    inValid = 1'b0;
    check("R11 result unaffected", packOut(), refModel(8'h27, 8'h15, 0, 1, 1, 0));
    @(negedge clk);
    check("R11 no second accept", int'(inReady), 1);
    check("R11 outValid low", int'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    resetScenario();
    binaryScenario();
    decimalDirected();
    variantSweep(1'b0, "R5 older decimal add", "R5 older decimal sub");
    variantSweep(1'b1, "R6 newer decimal add", "R6 newer decimal sub");
    invalidNibbles();
    holdScenario();
    busyScenario();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule